// File: doc/BRIEF.md
# Configurable Overcurrent Protection Controller

This block decides how a motor gate driver reacts when its per-phase overcurrent comparators trip. A two-bit response field selects one of four behaviours: limiting, latched shutdown, report-only, or disabled. In limiting mode the tripped phase's gates are forced off. Recovery then follows one of two rules chosen by a single bit. The first rule releases the gates at the next PWM cycle-start strobe. The second releases them after a fixed number of clock cycles, given as a parameter.

The block also keeps sticky status bits for overcurrent (one per phase) and for overtemperature, which a fault-reset pulse clears. It drives an active-low warning pin. A two-bit select routes overtemperature, overcurrent, or both to that pin. All outputs are registered on the same edge, so each output responds on the clock edge that samples its input.

Top module: `ocp_ctrl`

## Requirements
- R1: While reset is held and on release, `gate_off` and `oc_status` are all zero, `shutdown` and `ot_status` are 0, and `warn_n` is 1.
- R2: With `oc_mode`=00 and `toff_en`=0, `gate_off[i]` is 1 from the edge after `oc_det[i]` is sampled high. It stays 1 until the first edge that samples `pwm_start`=1 while `oc_det[i]`=0.
- R3: With `oc_mode`=00 and `toff_en`=1, `gate_off[i]` stays 1 for exactly `TOFF_CYC` edges after the last edge that sampled `oc_det[i]` high, and then clears. `pwm_start` has no effect in this case.
- R4: In limiting mode each phase is independent: a trip on one phase leaves the other phases' `gate_off` bits at 0.
- R5: With `oc_mode`=01, any sampled `oc_det` bit sets `shutdown`, and `gate_off` is then all ones. Both hold, whatever the inputs or the mode, until an edge samples `fault_clr`=1.
- R6: With `oc_mode`=10, an overcurrent sets the matching `oc_status` bit. `gate_off` and `shutdown` stay 0.
- R7: With `oc_mode`=11, `oc_det` is ignored: it changes no `oc_status` bit, no `gate_off` bit, no `shutdown`, and no `warn_n`.
- R8: `oc_status[i]` and `ot_status` are sticky, set when a counted overcurrent or `ot_warn` is sampled. An edge sampling `fault_clr`=1 clears them and `shutdown`, and the clear wins over a simultaneous event.
- R9: On each edge `warn_n` takes the inverse of a value chosen by `warn_sel`. With 00 that value is `ot_warn` OR any counted overcurrent. With 01 it is `ot_warn` alone. With 10 or 11 it is any counted overcurrent.
- R10: Selecting any mode other than 00 drops all limiting state at the next edge, so `gate_off` then shows only `shutdown`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| oc_det | input | N_PH | Per-phase overcurrent comparator flags |
| ot_warn | input | 1 | Overtemperature warning |
| pwm_start | input | 1 | PWM cycle-start strobe |
| oc_mode | input | 2 | Response: 00 limit, 01 latch, 10 report, 11 off |
| toff_en | input | 1 | 0 = cycle-by-cycle recovery, 1 = fixed off time |
| warn_sel | input | 2 | Warning pin routing select |
| fault_clr | input | 1 | Fault reset pulse |
| gate_off | output | N_PH | Per-phase gate-off request |
| shutdown | output | 1 | Latched shutdown flag |
| oc_status | output | N_PH | Sticky per-phase overcurrent status |
| ot_status | output | 1 | Sticky overtemperature status |
| warn_n | output | 1 | Active-low warning pin |

## Verification
The bench targets the edges of recovery. It pulses `pwm_start` while a phase is still tripped and again while a timed off period is running. A design that confused the two recovery rules would release the gates early or hold them too long. The bench also changes mode while a shutdown is latched, and asserts `fault_clr` in the same cycle as a fresh trip. A faulty latch would lose the shutdown on the mode change or keep stale status after the clear. It also trips a phase while protection is disabled and walks every `warn_sel` code, so leaks through the disabled path and wrong pin routing both show on the ports.

// File: rtl/ocp_pkg.sv
package ocp_pkg;
  typedef enum logic [1:0] {
    RESP_LIMIT  = 2'b00,
    RESP_LATCH  = 2'b01,
    RESP_REPORT = 2'b10,
    RESP_OFF    = 2'b11
  } oc_resp_e;

  // warning pin source selection (active-high result)
  function automatic logic warn_route(input logic [1:0] sel, input logic ot, input logic oc_any);
    case (sel)
      2'b00:   warn_route = ot | oc_any;
      2'b01:   warn_route = ot;
      default: warn_route = oc_any;
    endcase
  endfunction
endpackage

// File: rtl/ocp_phase_lim.sv
module ocp_phase_lim #(
  parameter int TOFF_CYC = 16,
  localparam int CW = (TOFF_CYC < 2) ? 1 : $clog2(TOFF_CYC)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lim_en,
  input  logic toff_en,
  input  logic oc,
  input  logic pwm_start,
  output logic lim
);
  localparam logic [CW-1:0] RELOAD = CW'(TOFF_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim <= 1'b0;
      cnt <= '0;
    end else if (!lim_en) begin
      lim <= 1'b0;
      cnt <= '0;
    end else if (oc) begin
      lim <= 1'b1;
      cnt <= RELOAD;
    end else if (lim) begin
      if (toff_en) begin
        if (cnt == '0) lim <= 1'b0;
        else           cnt <= cnt - 1'b1;
      end else if (pwm_start) begin
        lim <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ocp_status.sv
module ocp_status #(
  parameter int N_PH = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_PH-1:0] oc_eff,
  input  logic            ot_warn,
  input  logic [1:0]      warn_sel,
  input  logic            fault_clr,
  output logic [N_PH-1:0] oc_status,
  output logic            ot_status,
  output logic            warn_n
);
  import ocp_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oc_status <= '0;
      ot_status <= 1'b0;
      warn_n    <= 1'b1;
    end else begin
      warn_n <= ~warn_route(warn_sel, ot_warn, |oc_eff);
      if (fault_clr) begin
        oc_status <= '0;
        ot_status <= 1'b0;
      end else begin
        oc_status <= oc_status | oc_eff;
        ot_status <= ot_status | ot_warn;
      end
    end
  end
endmodule

// File: rtl/ocp_ctrl.sv
module ocp_ctrl #(
  parameter int N_PH     = 3,
  parameter int TOFF_CYC = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_PH-1:0] oc_det,
  input  logic            ot_warn,
  input  logic            pwm_start,
  input  logic [1:0]      oc_mode,
  input  logic            toff_en,
  input  logic [1:0]      warn_sel,
  input  logic            fault_clr,
  output logic [N_PH-1:0] gate_off,
  output logic            shutdown,
  output logic [N_PH-1:0] oc_status,
  output logic            ot_status,
  output logic            warn_n
);
  import ocp_pkg::*;

  oc_resp_e        resp;
  logic [N_PH-1:0] oc_eff;
  logic [N_PH-1:0] lim_vec;
  logic            lim_en;
  logic            trip_evt;

  assign resp     = oc_resp_e'(oc_mode);
  assign oc_eff   = (resp == RESP_OFF) ? '0 : oc_det;
  assign lim_en   = (resp == RESP_LIMIT);
  assign trip_evt = (resp == RESP_LATCH) && (|oc_eff);

  for (genvar g = 0; g < N_PH; g++) begin : g_ph
    ocp_phase_lim #(.TOFF_CYC(TOFF_CYC)) u_lim (
      .clk       (clk),
      .rst_n     (rst_n),
      .lim_en    (lim_en),
      .toff_en   (toff_en),
      .oc        (oc_eff[g]),
      .pwm_start (pwm_start),
      .lim       (lim_vec[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         shutdown <= 1'b0;
    else if (fault_clr) shutdown <= 1'b0;
    else if (trip_evt)  shutdown <= 1'b1;
  end

  assign gate_off = lim_vec | {N_PH{shutdown}};

  ocp_status #(.N_PH(N_PH)) u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .oc_eff    (oc_eff),
    .ot_warn   (ot_warn),
    .warn_sel  (warn_sel),
    .fault_clr (fault_clr),
    .oc_status (oc_status),
    .ot_status (ot_status),
    .warn_n    (warn_n)
  );
endmodule

// File: rtl/ocp_ctrl_chk.sv
module ocp_ctrl_chk #(
  parameter int N_PH = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic [N_PH-1:0] oc_det,
  input logic            ot_warn,
  input logic [1:0]      oc_mode,
  input logic [1:0]      warn_sel,
  input logic            fault_clr,
  input logic [N_PH-1:0] gate_off,
  input logic            shutdown,
  input logic [N_PH-1:0] oc_status,
  input logic            warn_n
);
  AST_LIM_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_mode == 2'b00 && oc_det[0]) |=> gate_off[0]); // R2

  AST_SHDN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (shutdown && !fault_clr) |=> shutdown); // R5

  AST_SHDN_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |-> (&gate_off)); // R5

  AST_REPORT_NO_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_mode == 2'b10 && !shutdown) |=> (gate_off == '0)); // R6

  AST_OFF_NO_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_mode == 2'b11 && fault_clr) |=> (oc_status == '0)); // R7

  AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    fault_clr |=> (oc_status == '0 && !shutdown)); // R8

  AST_WARN_OT: assert property (@(posedge clk) disable iff (!rst_n)
    (warn_sel == 2'b01 && ot_warn) |=> !warn_n); // R9

  AST_NOT_LIM_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_mode != 2'b00 && !shutdown && !(oc_mode == 2'b01 && |oc_det)) |=> (gate_off == '0)); // R10
endmodule

bind ocp_ctrl ocp_ctrl_chk #(.N_PH(N_PH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .oc_det    (oc_det),
  .ot_warn   (ot_warn),
  .oc_mode   (oc_mode),
  .warn_sel  (warn_sel),
  .fault_clr (fault_clr),
  .gate_off  (gate_off),
  .shutdown  (shutdown),
  .oc_status (oc_status),
  .warn_n    (warn_n)
);

// File: tb/ocp_ctrl_tb.sv
module ocp_ctrl_tb;
  localparam int NP   = 3;
  localparam int TOFF = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] oc_det = '0;
  logic          ot_warn = 1'b0, pwm_start = 1'b0, toff_en = 1'b0, fault_clr = 1'b0;
  logic [1:0]    oc_mode = 2'b00, warn_sel = 2'b00;
  logic [NP-1:0] gate_off, oc_status;
  logic          shutdown, ot_status, warn_n;

  int checks = 0, errors = 0, cyc = 0;

  always #2 clk = ~clk;

  ocp_ctrl #(.N_PH(NP), .TOFF_CYC(TOFF)) u_dut (
    .clk(clk), .rst_n(rst_n), .oc_det(oc_det), .ot_warn(ot_warn), .pwm_start(pwm_start),
    .oc_mode(oc_mode), .toff_en(toff_en), .warn_sel(warn_sel), .fault_clr(fault_clr),
    .gate_off(gate_off), .shutdown(shutdown), .oc_status(oc_status),
    .ot_status(ot_status), .warn_n(warn_n)
  );

  // behavioural reference model
  bit m_lim[NP];
  int m_left[NP];
  bit m_sd, m_ots, m_wn;
  bit m_ocs[NP];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_lim[i]) begin m_lim[i] = 0; m_left[i] = 0; m_ocs[i] = 0; end
      m_sd = 0; m_ots = 0; m_wn = 1;
    end else begin
      bit any_oc;
      bit counted;
      counted = (oc_mode != 2'b11);
      any_oc = counted && (oc_det != 0);
      foreach (m_lim[i]) begin
        if (oc_mode != 2'b00) begin
          m_lim[i] = 0;
          m_left[i] = 0;
        end else if (oc_det[i]) begin
          m_lim[i] = 1;
          m_left[i] = TOFF;
        end else if (m_lim[i]) begin
          if (toff_en) begin
            m_left[i] = m_left[i] - 1;
            if (m_left[i] == 0) m_lim[i] = 0;
          end else if (pwm_start) begin
            m_lim[i] = 0;
          end
        end
        m_ocs[i] = fault_clr ? 1'b0 : (m_ocs[i] | (counted & oc_det[i]));
      end
      if (fault_clr) m_sd = 0;
      else if (oc_mode == 2'b01 && any_oc) m_sd = 1;
      m_ots = fault_clr ? 1'b0 : (m_ots | ot_warn);
      if (warn_sel == 2'b00)      m_wn = !(ot_warn || any_oc);
      else if (warn_sel == 2'b01) m_wn = !ot_warn;
      else                        m_wn = !any_oc;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
    end
  endtask

  // per-clock comparison against the model, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      string greq;
      logic [NP-1:0] eg, eo;
      foreach (m_lim[i]) begin
        eg[i] = m_lim[i] | m_sd;
        eo[i] = m_ocs[i];
      end
      case (oc_mode)
        2'b00:   greq = toff_en ? "R3" : "R2";
        2'b01:   greq = "R5";
        2'b10:   greq = "R6";
        default: greq = "R7";
      endcase
      chk(gate_off == eg, greq, gate_off, eg);
      chk(shutdown == m_sd, "R5", shutdown, m_sd);
      chk(oc_status == eo, "R8", oc_status, eo);
      chk(ot_status == m_ots, "R8", ot_status, m_ots);
      chk(warn_n == m_wn, "R9", warn_n, m_wn);
    end
    if (cyc > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired at cycle %0d: actual hang expected finish", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    step(3);
    chk(gate_off == 0 && !shutdown && oc_status == 0 && !ot_status && warn_n, "R1", gate_off, 0);
    rst_n = 1'b1;
    step(2);
    chk(gate_off == 0 && warn_n == 1'b1, "R1", {gate_off, warn_n}, 1);

    // R2: cycle-by-cycle limiting, R4 per-phase independence
    oc_det = 3'b001; step(1);
    chk(gate_off == 3'b001, "R2 R4", gate_off, 1);
    pwm_start = 1'b1; step(1);   // still tripped, stays off
    chk(gate_off[0] == 1'b1, "R2", gate_off[0], 1);
    pwm_start = 1'b0; oc_det = 3'b000; step(3);
    chk(gate_off[0] == 1'b1, "R2", gate_off[0], 1);
    pwm_start = 1'b1; step(1);
    chk(gate_off[0] == 1'b0, "R2", gate_off[0], 0);
    pwm_start = 1'b0; step(2);

    // R3: timed off period, pwm_start ignored
    toff_en = 1'b1; oc_det = 3'b100; step(2);
    oc_det = 3'b000; pwm_start = 1'b1; step(TOFF - 1);
    chk(gate_off[2] == 1'b1, "R3", gate_off[2], 1);
    pwm_start = 1'b0; step(1);
    chk(gate_off[2] == 1'b0, "R3", gate_off[2], 0);
    chk(gate_off[1:0] == 2'b00, "R4", gate_off[1:0], 0);
    toff_en = 1'b0;

    // R10: leaving limit mode drops limiting
    oc_det = 3'b010; step(1);
    oc_det = 3'b000; oc_mode = 2'b10; step(1);
    chk(gate_off == 0, "R10", gate_off, 0);

    // R8: clear wins over new event
    fault_clr = 1'b1; oc_det = 3'b011; ot_warn = 1'b1; step(1);
    chk(oc_status == 0 && !ot_status, "R8", oc_status, 0);
    fault_clr = 1'b0; oc_det = 3'b000; ot_warn = 1'b0; step(1);

    // R6: report only
    oc_det = 3'b110; step(1);
    oc_det = 3'b000; step(2);
    chk(oc_status == 3'b110 && gate_off == 0 && !shutdown, "R6", {oc_status, gate_off}, 6 << NP);

    // R5: latched shutdown survives mode change
    fault_clr = 1'b1; step(1); fault_clr = 1'b0;
    oc_mode = 2'b01; oc_det = 3'b010; step(1);
    oc_det = 3'b000; step(4);
    chk(shutdown && gate_off == 3'b111, "R5", {shutdown, gate_off}, 15);
    oc_mode = 2'b10; step(3);
    chk(shutdown == 1'b1, "R5", shutdown, 1);
    fault_clr = 1'b1; step(1); fault_clr = 1'b0;
    chk(!shutdown && gate_off == 0, "R5 R8", {shutdown, gate_off}, 0);

    // R7: disabled
    oc_mode = 2'b11; warn_sel = 2'b10; oc_det = 3'b111; step(3);
    chk(oc_status == 0 && gate_off == 0 && warn_n, "R7", {oc_status, gate_off, warn_n}, 1);
    oc_det = 3'b000; step(1);

    // R9: warning routing
    oc_mode = 2'b10;
    for (int s = 0; s < 4; s++) begin
      warn_sel = 2'(s);
      ot_warn = 1'b1; oc_det = 3'b000; step(1);
      chk(warn_n == !(s < 2), "R9 ot", warn_n, !(s < 2));
      ot_warn = 1'b0; oc_det = 3'b001; step(1);
      chk(warn_n == (s == 1), "R9 oc", warn_n, (s == 1));
      oc_det = 3'b000; step(1);
      chk(warn_n == 1'b1, "R9 idle", warn_n, 1);
    end
    step(4);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule